// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block watches for a stalled program. Once software sets its enable bit, a counter advances on every pulse of a slow tick input, which stands in for a separate low-rate watchdog oscillator. Software must restart the counter by strobing a kick input before the count reaches a limit. The limit is chosen by a 3-bit timeout code. If the limit is reached, the block drives a system reset pulse for exactly one clock cycle. It also sets a sticky cause flag, so that code running after the reset can tell why the reset happened. The counter then starts again from zero.

Turning the watchdog off is deliberately awkward. A plain write that clears the enable bit is discarded. Software must first make a single write with both the enable bit and an unlock bit set. That write opens a window of four clock cycles, and only during that window does a write that clears the enable bit take effect. The unlock bit clears itself when the window ends. The timeout base is a parameter: `BASE_LOG2` = 14 gives limits of 16K up to 2048K ticks.

Top module: `wdog_guard`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0 (watchdog disabled, timeout code 0, unlock bit 0), and `sys_rst_pulse` and `cause_flag` are both 0.
- R2: The control word has the timeout code in bits [2:0], the enable bit in bit 3 and the unlock bit in bit 4. While the watchdog is disabled, a write stores the code and the enable bit as written, and `rd_data` returns them.
- R3: With timeout code c, the limit is 2^(BASE_LOG2+c) ticks. Counting from an enable write with `tick` held high, `sys_rst_pulse` rises on the clock edge of the limit-th tick.
- R4: The counter advances only in cycles where `tick` is high. While `tick` is low, no timeout can occur.
- R5: `sys_rst_pulse` is exactly one clock cycle wide. The counter restarts from zero at the timeout, so the next pulse comes one full limit later.
- R6: A timeout sets `cause_flag` in the same cycle that the pulse rises. The flag stays set until `cause_clr` is strobed. A timeout in the same cycle as a clear leaves the flag set.
- R7: A `kick` strobe clears the counter, so the next timeout comes one full limit of ticks after the kick edge. The enable bit and the code are not changed, and a kick cycle never produces a pulse.
- R8: A write with both bit 3 and bit 4 set opens an unlock window. Bit 4 reads 1 for the four cycles after that write and then reads 0.
- R9: A write with bit 3 clear, made while the unlock window is open, disables the watchdog, stores the new code and closes the window.
- R10: While the watchdog is enabled and the window is closed, a write with bit 3 clear is discarded entirely: the enable bit stays 1 and the code does not change.
- R11: While the watchdog is disabled, the counter is held at zero and no pulse is produced. A later enable gives a full limit before the timeout.
- R12: A code written while the watchdog is enabled is compared against the current count. If the count already meets or exceeds the new limit, the timeout occurs on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable for each watchdog oscillator period |
| kick | input | 1 | Restart strobe that clears the counter |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Control word to write |
| rd_data | output | 5 | Control register readback: {unlock, enable, code} |
| cause_clr | input | 1 | Clears the sticky cause flag |
| sys_rst_pulse | output | 1 | One-cycle reset request on timeout |
| cause_flag | output | 1 | Sticky flag showing a watchdog timeout happened |

## Verification
The assertions check several rules on every cycle. The pulse is one cycle wide and always comes with the flag. The flag stays set without a clear. A kick cycle and a disabled cycle never lead to a pulse. A closed-window write never disables the watchdog, and an open-window write always does. Only the bench scenarios show the timing of each timeout: the exact tick count for several codes, the restart after a kick, the four-cycle length of the unlock window, the stall while `tick` is low, and an immediate timeout after the code is lowered.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // control word layout
  localparam int CODE_W   = 3;
  localparam int REG_W    = 5;
  localparam int CODE_LSB = 0;
  localparam int EN_BIT   = 3;
  localparam int UNL_BIT  = 4;
  localparam int NCODES   = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             en,
  output code_t            code,
  output logic             unlock_open
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  logic             en_q;
  code_t            code_q;
  logic [WIN_W-1:0] win_q;
  logic             en_n;
  code_t            code_n;
  logic [WIN_W-1:0] win_n;
  logic             req_en;
  logic             req_unl;
  code_t            req_code;

  assign req_en   = wr_data[EN_BIT];
  assign req_unl  = wr_data[UNL_BIT] & wr_data[EN_BIT];
  assign req_code = wr_data[CODE_LSB +: CODE_W];

  always_comb begin
    en_n   = en_q;
    code_n = code_q;
    win_n  = (win_q != '0) ? win_q - WIN_W'(1) : '0;
    if (wr_en) begin
      if (!en_q) begin
        // disabled: write taken as is
        en_n   = req_en;
        code_n = req_code;
        if (req_unl) win_n = WIN_W'(WIN_CYCLES);
      end else if (req_en) begin
        // stays enabled, code may change
        code_n = req_code;
        if (req_unl) win_n = WIN_W'(WIN_CYCLES);
      end else if (win_q != '0) begin
        // guarded disable accepted
        en_n   = 1'b0;
        code_n = req_code;
        win_n  = '0;
      end
      // else: closed window, write discarded
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      code_q <= '0;
      win_q  <= '0;
    end else begin
      en_q   <= en_n;
      code_q <= code_n;
      win_q  <= win_n;
    end
  end

  assign en          = en_q;
  assign code        = code_q;
  assign unlock_open = (win_q != '0);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  code_t code,
  input  logic  tick,
  input  logic  kick,
  output logic  hit
);
  localparam int CNT_W = BASE_LOG2 + NCODES;

  logic [CNT_W-1:0] lim_tab [NCODES];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             reach;

  for (genvar gi = 0; gi < NCODES; gi++) begin : g_lim
    assign lim_tab[gi] = CNT_W'(1) << (BASE_LOG2 + gi);
  end

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    reach   = (cnt_inc >= lim_tab[code]);
    hit     = en & ~kick & tick & reach;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || kick) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= reach ? '0 : cnt_inc;
    end
  end
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic pulse,
  output logic flag
);
  logic pulse_q;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;
  assign flag  = flag_q;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2  = 14,
  parameter int WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             cause_clr,
  output logic             sys_rst_pulse,
  output logic             cause_flag
);
  logic  en;
  code_t code;
  logic  unlock_open;
  logic  hit;

  wdog_ctrl_reg #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .en         (en),
    .code       (code),
    .unlock_open(unlock_open)
  );

  wdog_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .code(code),
    .tick(tick),
    .kick(kick),
    .hit (hit)
  );

  wdog_cause u_cause (
    .clk  (clk),
    .rst  (rst),
    .hit  (hit),
    .clr  (cause_clr),
    .pulse(sys_rst_pulse),
    .flag (cause_flag)
  );

  always_comb begin
    rd_data                       = '0;
    rd_data[CODE_LSB +: CODE_W]   = code;
    rd_data[EN_BIT]               = en;
    rd_data[UNL_BIT]              = unlock_open;
  end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             kick,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             cause_clr,
  input logic             sys_rst_pulse,
  input logic             cause_flag
);
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_pulse |=> !sys_rst_pulse);

  // R6
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_pulse |-> cause_flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_flag && !cause_clr) |=> cause_flag);

  // R7
  kick_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> !sys_rst_pulse);

  // R11
  off_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[EN_BIT] |=> !sys_rst_pulse);

  // R10
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[EN_BIT] && !rd_data[UNL_BIT] && wr_en && !wr_data[EN_BIT])
      |=> (rd_data[EN_BIT] && $stable(rd_data[CODE_LSB +: CODE_W])));

  // R9
  unlocked_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[UNL_BIT] && wr_en && !wr_data[EN_BIT]) |=> !rd_data[EN_BIT]);
endmodule

bind wdog_guard wdog_guard_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .kick         (kick),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .cause_clr    (cause_clr),
  .sys_rst_pulse(sys_rst_pulse),
  .cause_flag   (cause_flag)
);

// File: tb/sim_wdog_guard.sv
`timescale 1ns/1ps
module sim_wdog_guard;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       kick = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic       cause_clr = 1'b0;
  logic       sys_rst_pulse;
  logic       cause_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wdog_guard #(.BASE_LOG2(BASE), .WIN_CYCLES(4)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cause_clr(cause_clr), .sys_rst_pulse(sys_rst_pulse),
    .cause_flag(cause_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic wr(input logic [4:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic turn_off();
    tick = 1'b0;
    wr(5'h18);
    wr(5'h00);
  endtask

  // edges until first pulse (0 = none); also checks width (R5)
  task automatic wait_pulse(input int maxn, output int n);
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      step();
      if (sys_rst_pulse && n == 0) begin
        n = i;
        step();
        check("R5 width", int'(sys_rst_pulse), 0);
        break;
      end
    end
  endtask

  task automatic t_reset();
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 pulse", int'(sys_rst_pulse), 0);
    check("R1 flag", int'(cause_flag), 0);
  endtask

  task automatic t_basic();
    int n;
    tick = 1'b1;
    wr(5'h08);
    check("R2 readback", int'(rd_data), 8);
    wait_pulse(40, n);
    check("R3 code0 limit", n, 16);
    check("R6 flag set", int'(cause_flag), 1);
    // counter restarted at edge 16; one edge consumed by width check
    wait_pulse(40, n);
    check("R5 restart", n, 15);
  endtask

  task automatic t_flag();
    tick = 1'b0;
    idle(20);
    check("R6 sticky", int'(cause_flag), 1);
    cause_clr = 1'b1; step(); cause_clr = 1'b0;
    check("R6 cleared", int'(cause_flag), 0);
  endtask

  task automatic t_window();
    tick = 1'b0;
    wr(5'h00);
    check("R10 plain off ignored", int'(rd_data), 8);
    wr(5'h05);
    check("R10 code kept", int'(rd_data), 8);
    wr(5'h18);
    check("R8 unlock reads 1", int'(rd_data), 5'h18);
    idle(3);
    check("R8 still open", int'(rd_data), 5'h18);
    idle(1);
    check("R8 window closed", int'(rd_data), 8);
    wr(5'h00);
    check("R10 late off ignored", int'(rd_data), 8);
  endtask

  task automatic t_disable();
    int n;
    wr(5'h18);
    idle(3);
    wr(5'h02);
    check("R9 disabled", int'(rd_data), 2);
    tick = 1'b1;
    kick = 1'b1; step(); kick = 1'b0;
    wait_pulse(200, n);
    check("R11 no pulse when off", n, 0);
    wr(5'h08);
    wait_pulse(40, n);
    check("R11 full period after enable", n, 16);
  endtask

  task automatic t_tick();
    int n;
    turn_off();
    wr(5'h08);
    wait_pulse(100, n);
    check("R4 no tick no timeout", n, 0);
    tick = 1'b1;
    wait_pulse(40, n);
    check("R4 counts ticks", n, 16);
  endtask

  task automatic t_kick();
    int n;
    turn_off();
    tick = 1'b1;
    wr(5'h09);
    idle(20);
    kick = 1'b1; step(); kick = 1'b0;
    check("R7 config kept", int'(rd_data), 9);
    wait_pulse(80, n);
    check("R7 full limit after kick", n, 32);
  endtask

  task automatic t_codes();
    int n;
    turn_off();
    tick = 1'b1;
    wr(5'h0B);
    wait_pulse(200, n);
    check("R3 code3 limit", n, 128);
    turn_off();
    tick = 1'b1;
    wr(5'h0F);
    wait_pulse(2100, n);
    check("R3 code7 limit", n, 2048);
  endtask

  task automatic t_shrink();
    int n;
    turn_off();
    tick = 1'b1;
    wr(5'h0B);
    idle(99);
    tick = 1'b0;
    wr(5'h08);
    check("R12 code changed", int'(rd_data), 8);
    tick = 1'b1;
    wait_pulse(10, n);
    check("R12 fires next tick", n, 1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_basic();
    t_flag();
    t_window();
    t_disable();
    t_tick();
    t_kick();
    t_codes();
    t_shrink();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule